// File: doc/BRIEF.md
# Prescaled Event Timer with Atomic Wide Access

This peripheral counts either internal instruction-cycle ticks or edges on an external input pin. It can count 8 or 16 bits wide, and an optional power-of-two prescaler can sit in front of the count. The external pin passes through a synchronizer that is clocked by the tick before an edge can advance the count. When the count rolls over, a sticky flag is raised for an interrupt controller to pick up.

Software reaches the block through a small byte-wide register port with four addresses:

| Address | Register |
|---|---|
| 0 | Low count byte |
| 1 | High-byte buffer |
| 2 | Control |
| 3 | Status |

In 16-bit mode the true high byte is hidden behind the buffer. A read of the low byte captures the high byte into the buffer. A write of the low byte commits the buffer into the high byte. Software can therefore read or write all 16 bits as one consistent value.

Top module: `evt_timer`

## Requirements
- R1: After reset the control register reads 0xA7, the low count reads 0x00 and the status register reads 0x00. The control value 0xA7 means running, 8-bit, external source, rising edge, prescaler in use, code 7. The control bit layout is: bit 7 run, bit 6 wide (1 = 16-bit), bit 5 source (1 = external pin), bit 4 edge (1 = falling), bit 3 bypass (1 = prescaler skipped), bits 2:0 prescale code.
- R2: With the internal source and bypass set, the count rises by one on every `cyc_tick` pulse.
- R3: With the prescaler in use, prescale code c gives one count per 2^(c+1) selected events. Any write to the low count clears the prescaler's partial count.
- R4: After a write to the low count (address 0), the next two `cyc_tick` pulses never advance the count.
- R5: With the external source and the edge bit at 0, a rising level on `ext_in` present before a tick advances the count on the third tick. The count responds two ticks after the tick that first sees the new level. Falling levels are ignored.
- R6: With the edge bit at 1, only falling levels on `ext_in` advance the count, with the same three-tick latency as R5.
- R7: In 16-bit mode, a read of address 0 copies the true high byte into the buffer that address 1 returns. A write to address 1 alone leaves the true high byte unchanged.
- R8: A write to address 0 loads the low byte from the write data. In 16-bit mode the same write also loads the true high byte from the buffer.
- R9: In 8-bit mode, an advance from 0xFF wraps the low byte to 0x00 and sets status bit 0 and `ovf_flag`. The flag stays set until software writes address 3 with bit 0 at 0.
- R10: In 16-bit mode the flag is set only when the count advances from 0xFFFF. An advance from 0x00FF carries into the high byte without setting the flag.
- R11: While the run bit is 0, the count does not move. All registers can still be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick | input | 1 | One-clock instruction-cycle enable |
| ext_in | input | 1 | External count input pin |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The properties assume that `cyc_tick` is a single-clock pulse and that `bus_addr` is only meaningful while a strobe is high. They also assume that a read strobe and a write strobe to the buffer address are never raised in the same clock. The bench drives every input at the falling clock edge, pulses the strobes for one clock at a time, and never combines a read with a write. It changes `ext_in` only between runs of ticks. As a result, each synchronizer stage sees a settled level, and the edge latency the bench expects is exactly the tick count given in the requirements.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int DW   = 8,
  parameter int PSW  = 3,
  parameter int SYNC = 2,
  parameter int HOLD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_tick,
  input  logic          ext_in,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          ovf_flag
);
  localparam int PW = 1 << PSW;
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [1:0] A_LO = 2'd0, A_HB = 2'd1, A_CT = 2'd2, A_ST = 2'd3;
  localparam logic [DW-1:0] CTRL_RST = DW'({1'b1, 1'b0, 1'b1, 1'b0, 1'b0, {PSW{1'b1}}});

  logic [DW-1:0] ctrl, lo, hi, hbuf;
  logic [PW-1:0] pcnt;
  logic [HW-1:0] inh;
  logic [SYNC:0] sy;
  logic          flag;

  wire run  = ctrl[7];
  wire wide = ctrl[6];
  wire src  = ctrl[5];
  wire edg  = ctrl[4];
  wire byp  = ctrl[3];
  wire [PSW-1:0] psel = ctrl[PSW-1:0];

  wire wr_lo = bus_wr && bus_addr == A_LO;
  wire wr_hb = bus_wr && bus_addr == A_HB;
  wire wr_ct = bus_wr && bus_addr == A_CT;
  wire wr_st = bus_wr && bus_addr == A_ST;
  wire rd_lo = bus_rd && bus_addr == A_LO;

  wire ext_cur = sy[SYNC-1] ^ edg;
  wire ext_prv = sy[SYNC] ^ edg;
  wire ext_evt = ext_cur & ~ext_prv;

  wire evt = cyc_tick && run && (inh == '0) && (src ? ext_evt : 1'b1);

  wire [PW-1:0] pnext = pcnt + 1'b1;
  wire [PW-1:0] pmask = (PW'(2) << psel) - 1'b1;
  wire          pdone = (pnext & pmask) == '0;

  wire            inc  = evt && (byp || pdone) && !wr_lo;
  wire [2*DW-1:0] full = {hi, lo};
  wire            ovf  = inc && (wide ? &full : &lo);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '0;
    else if (cyc_tick) sy <= {sy[SYNC-1:0], ext_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl <= CTRL_RST;
    else if (wr_ct) ctrl <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pcnt <= '0;
    else if (wr_lo) pcnt <= '0;
    else if (evt && !byp) pcnt <= pnext;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) inh <= '0;
    else if (wr_lo) inh <= HW'(HOLD);
    else if (cyc_tick && inh != '0) inh <= inh - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else if (wr_lo) begin
      lo <= bus_wdata;
      if (wide) hi <= hbuf;
    end else if (inc) begin
      if (wide) {hi, lo} <= full + 1'b1;
      else      lo <= lo + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hbuf <= '0;
    else if (wr_hb) hbuf <= bus_wdata;
    else if (rd_lo && wide) hbuf <= hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag <= 1'b0;
    else if (ovf) flag <= 1'b1;
    else if (wr_st && !bus_wdata[0]) flag <= 1'b0;

  always_comb
    case (bus_addr)
      A_LO:    bus_rdata = lo;
      A_HB:    bus_rdata = hbuf;
      A_CT:    bus_rdata = ctrl;
      default: bus_rdata = DW'(flag);
    endcase

  assign ovf_flag = flag;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          run,
  input logic          wide,
  input logic [DW-1:0] lo,
  input logic [DW-1:0] hi,
  input logic [DW-1:0] hbuf,
  input logic          flag
);
  wire w_lo = bus_wr && bus_addr == 2'd0;
  wire w_hb = bus_wr && bus_addr == 2'd1;
  wire w_cl = bus_wr && bus_addr == 2'd3 && !bus_wdata[0];

  // R8
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_lo |=> lo == $past(bus_wdata));

  // R8
  hi_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_lo && wide |=> hi == $past(hbuf));

  // R7
  buf_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 2'd0 && wide && !w_hb |=> hbuf == $past(hi));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !w_cl |=> flag);

  // R9
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> lo == '0);

  // R11
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !w_lo |=> lo == $past(lo) && hi == $past(hi));

  // R10
  narrow_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide && !w_lo |=> $stable(hi));
endmodule

bind evt_timer evt_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .run(run), .wide(wide),
  .lo(lo), .hi(hi), .hbuf(hbuf), .flag(flag)
);

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b0;
  logic       ext_in = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ovf_flag;

  int checks = 0;
  int errors = 0;

  evt_timer u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  // {ctrl, preload, ticks, expected low count}
  localparam logic [39:0] VEC [0:6] = '{
    {8'h88, 8'h10, 16'd10,  8'h18},  // R2 R4
    {8'h88, 8'hFE, 16'd3,   8'hFF},  // R2 R4
    {8'h80, 8'h00, 16'd10,  8'h04},  // R3 ratio 2
    {8'h81, 8'h00, 16'd18,  8'h04},  // R3 ratio 4
    {8'h82, 8'h05, 16'd26,  8'h08},  // R3 ratio 8
    {8'h87, 8'h00, 16'd257, 8'h00},  // R3 ratio 256, one short
    {8'h08, 8'h33, 16'd10,  8'h33}   // R11 stopped
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc_tick = 1'b1;
    end
    @(negedge clk);
    cyc_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd2, v); check("R1 ctrl", v, 8'hA7);
    rd(2'd0, v); check("R1 count", v, 8'h00);
    rd(2'd3, v); check("R1 status", v, 8'h00);

    for (int i = 0; i < 7; i++) begin
      wr(2'd2, VEC[i][39:32]);
      wr(2'd0, VEC[i][31:24]);
      ticks(int'(VEC[i][23:8]));
      rd(2'd0, v);
      check("R2/R3/R4/R11 vector", v, VEC[i][7:0]);
    end

    // R5 rising edge through synchronizer
    wr(2'd2, 8'hA8);
    wr(2'd0, 8'h00);
    ticks(5);
    ext_in = 1'b1;
    ticks(2); rd(2'd0, v); check("R5 before latency", v, 8'h00);
    ticks(1); rd(2'd0, v); check("R5 after latency", v, 8'h01);
    ext_in = 1'b0;
    ticks(4); rd(2'd0, v); check("R5 fall ignored", v, 8'h01);

    // R6 falling edge
    wr(2'd2, 8'hB8);
    wr(2'd0, 8'h00);
    ticks(3);
    ext_in = 1'b1;
    ticks(4); rd(2'd0, v); check("R6 rise ignored", v, 8'h00);
    ext_in = 1'b0;
    ticks(2); rd(2'd0, v); check("R6 before latency", v, 8'h00);
    ticks(1); rd(2'd0, v); check("R6 after latency", v, 8'h01);

    // R7 R8 16-bit atomic access
    wr(2'd2, 8'h48);
    wr(2'd1, 8'h12);
    wr(2'd0, 8'h34);
    rd(2'd0, v); check("R8 low", v, 8'h34);
    rd(2'd1, v); check("R7 high via buffer", v, 8'h12);
    wr(2'd1, 8'h99);
    rd(2'd0, v);
    rd(2'd1, v); check("R7 buffer write leaves high", v, 8'h12);

    // R10 wide carry and wide overflow
    wr(2'd2, 8'hC8);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hFF);
    ticks(3);
    rd(2'd0, v); check("R10 carry low", v, 8'h00);
    rd(2'd1, v); check("R10 carry high", v, 8'h01);
    check("R10 no flag on byte carry", {7'd0, ovf_flag}, 8'h00);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'hFE);
    ticks(3);
    check("R10 no flag at FFFF", {7'd0, ovf_flag}, 8'h00);
    ticks(1);
    rd(2'd0, v); check("R10 wrap low", v, 8'h00);
    rd(2'd1, v); check("R10 wrap high", v, 8'h00);
    check("R10 flag", {7'd0, ovf_flag}, 8'h01);

    // R9 8-bit overflow, sticky flag
    wr(2'd2, 8'h88);
    wr(2'd3, 8'h00);
    check("R9 cleared", {7'd0, ovf_flag}, 8'h00);
    wr(2'd0, 8'hFF);
    ticks(3);
    rd(2'd0, v); check("R9 wrap", v, 8'h00);
    rd(2'd3, v); check("R9 status", v, 8'h01);
    ticks(2);
    wr(2'd3, 8'h01);
    check("R9 sticky", {7'd0, ovf_flag}, 8'h01);
    wr(2'd3, 8'h00);
    check("R9 clear", {7'd0, ovf_flag}, 8'h00);

    // R11 registers writable while stopped
    wr(2'd2, 8'h08);
    wr(2'd0, 8'h5A);
    ticks(6);
    rd(2'd0, v); check("R11 write while stopped", v, 8'h5A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule